// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Request Timeout and Grant Parking

This block shares one bus among a parameterized number of masters. Each master raises a bit of the request vector. The arbiter answers with a registered grant vector that has at most one bit set. The winner comes from a fixed priority order. By default the lowest index wins, and a parameter reverses this so the highest index wins.

While the bus reports busy, the grant does not move. A master of higher priority that asks during a transfer must wait until the transfer ends. When busy drops, the arbiter inserts one cycle with no grant before it picks again.

Two additions sit on top of the plain priority choice:

- **Request timeout.** A per-master timeout takes the bus back from a master that keeps requesting for too long while another master waits. The revoked master is left out of the next choice.
- **Grant parking.** When nobody requests, the grant is parked by one of two policies, chosen by a parameter:
  - keep it with the most recent owner, or
  - hand it to a fixed default master.

Top module: `prio_bus_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle.
- R2: While `rst_i` is high, all grant bits are low. The timeout counters, the busy history and the last-owner record are also cleared.
- R3: On any clock edge where `bus_busy_i` is high, `grant_o` keeps its value. A newly arriving request of higher priority does not displace the current owner.
- R4: On the first edge where `bus_busy_i` is sampled low after being high on the previous edge, `grant_o` becomes all zero for exactly that one cycle. Normal selection resumes at the following edge.
- R5: With `HIGH_WINS=0`, an idle edge grants the lowest-indexed requesting master. Bit i of `grant_o` corresponds to bit i of `req_i`. The grant appears on the output of the same edge that samples the request.
- R6: With `HIGH_WINS=1`, an idle edge grants the highest-indexed requesting master.
- R7: A master whose request and grant are both high for `TIMEOUT_CYCLES+1` consecutive idle edges has its grant removed at the next idle edge if any other request is high. `grant_o` is zero for that cycle. With the default limit of 10, the grant is visible for 11 cycles and is gone in the 12th.
- R8: A master that requests alone keeps its grant indefinitely. No timeout revocation happens without another pending request.
- R9: After a timeout revocation, the next arbitration excludes the revoked master whenever another master still requests. This applies even if the revoked master has higher priority.
- R10: A master's timeout count restarts from zero whenever its request or its grant is low on a clock edge.
- R11: With `PARK_MODE=PARK_LAST` and no request, the grant stays with, or returns to, the master that last won a request.
- R12: With `PARK_MODE=PARK_LAST`, if no master has won since reset and no request is present, `grant_o` stays all zero.
- R13: With `PARK_MODE=PARK_DEFAULT` and no request, an idle edge grants master `DEFAULT_MASTER`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Asynchronous reset, active high |
| req_i | input | N_MASTERS | Request from each master, bit i for master i |
| bus_busy_i | input | 1 | High while the current owner is running a transfer |
| grant_o | output | N_MASTERS | Registered grant, at most one bit set |

## Verification
The bench builds two copies of the arbiter, each with four masters.

- **First copy:** low-index priority, last-owner parking and a limit of 10. This reaches the exact 11-cycle timeout boundary, the masking of the revoked master, the restart of a count after a dropped request, and the all-zero park state before any grant.
- **Second copy:** high-index priority and default-master parking with master 2 as the default. This exercises the reversed order and the fallback grant.

Busy is driven the way a master holding the bus would drive it, which lets the freeze and the one-cycle release gap be observed at the grant outputs.

// File: rtl/pba_pkg.sv
package pba_pkg;
   typedef enum logic {
      PARK_LAST    = 1'b0,
      PARK_DEFAULT = 1'b1
   } park_mode_e;
endpackage

// File: rtl/pba_pick.sv
module pba_pick #(
   parameter int N_MASTERS = 4,
   parameter bit HIGH_WINS = 1'b0
) (
   input  logic [N_MASTERS-1:0] vec_i,
   output logic [N_MASTERS-1:0] pick_o
);
   if (HIGH_WINS) begin : g_high
      logic found;
      always_comb begin
         pick_o = '0;
         found  = 1'b0;
         for (int i = N_MASTERS-1; i >= 0; i--) begin
            if (vec_i[i] && !found) begin
               pick_o[i] = 1'b1;
               found     = 1'b1;
            end
         end
      end
   end else begin : g_low
      logic found;
      always_comb begin
         pick_o = '0;
         found  = 1'b0;
         for (int i = 0; i < N_MASTERS; i++) begin
            if (vec_i[i] && !found) begin
               pick_o[i] = 1'b1;
               found     = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pba_timeout.sv
module pba_timeout #(
   parameter int N_MASTERS = 4,
   parameter int LIMIT     = 10,
   parameter int CNT_W     = 4
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic [N_MASTERS-1:0]        req_i,
   input  logic [N_MASTERS-1:0]        grant_i,
   output logic [N_MASTERS-1:0]        expire_o,
   output logic [N_MASTERS*CNT_W-1:0]  cnt_flat_o
);
   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_cnt
      localparam logic [N_MASTERS-1:0] SELF = N_MASTERS'(1) << g;
      logic [CNT_W-1:0] cnt_q;
      logic             others;

      assign others = |(req_i & ~SELF);

      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            cnt_q <= '0;
         end else if (!(req_i[g] && grant_i[g])) begin
            cnt_q <= '0;
         end else if (cnt_q != LIMIT_C) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expire_o[g] = (cnt_q == LIMIT_C) && req_i[g] && grant_i[g] && others;
      assign cnt_flat_o[g*CNT_W +: CNT_W] = cnt_q;
   end
endmodule

// File: rtl/pba_park.sv
module pba_park
   import pba_pkg::*;
#(
   parameter int         N_MASTERS      = 4,
   parameter park_mode_e PARK_MODE      = PARK_LAST,
   parameter int         DEFAULT_MASTER = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 load_i,
   input  logic [N_MASTERS-1:0] load_vec_i,
   output logic [N_MASTERS-1:0] park_vec_o
);
   if (PARK_MODE == PARK_LAST) begin : g_last
      logic [N_MASTERS-1:0] last_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            last_q <= '0;
         end else if (load_i) begin
            last_q <= load_vec_i;
         end
      end
      assign park_vec_o = last_q;
   end else begin : g_default
      logic unused_park;
      assign unused_park = ^{clk_i, rst_i, load_i, load_vec_i};
      assign park_vec_o  = N_MASTERS'(1) << DEFAULT_MASTER;
   end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
   import pba_pkg::*;
#(
   parameter int         N_MASTERS      = 4,
   parameter bit         HIGH_WINS      = 1'b0,
   parameter int         TIMEOUT_CYCLES = 10,
   parameter park_mode_e PARK_MODE      = PARK_LAST,
   parameter int         DEFAULT_MASTER = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic                 bus_busy_i,
   output logic [N_MASTERS-1:0] grant_o
);
   localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

   if (N_MASTERS < 2) begin : g_bad_n
      $error("prio_bus_arbiter: N_MASTERS must be at least 2");
   end
   if (TIMEOUT_CYCLES < 1) begin : g_bad_to
      $error("prio_bus_arbiter: TIMEOUT_CYCLES must be at least 1");
   end
   if (DEFAULT_MASTER < 0 || DEFAULT_MASTER >= N_MASTERS) begin : g_bad_dm
      $error("prio_bus_arbiter: DEFAULT_MASTER out of range");
   end

   logic                       busy_q;
   logic                       release_edge;
   logic [N_MASTERS-1:0]       mask_q;
   logic [N_MASTERS-1:0]       eligible;
   logic [N_MASTERS-1:0]       pick_src;
   logic [N_MASTERS-1:0]       req_pick;
   logic [N_MASTERS-1:0]       park_vec;
   logic [N_MASTERS-1:0]       grant_next;
   logic [N_MASTERS-1:0]       expire;
   logic [N_MASTERS*CNT_W-1:0] cnt_flat;
   logic                       any_req;
   logic                       arb_load;

   assign release_edge = busy_q && !bus_busy_i;
   assign any_req      = |req_i;
   assign eligible     = req_i & ~mask_q;
   assign pick_src     = (|eligible) ? eligible : req_i;
   assign grant_next   = any_req ? req_pick : park_vec;
   assign arb_load     = !release_edge && !bus_busy_i && !(|expire) && any_req;

   pba_pick #(
      .N_MASTERS (N_MASTERS),
      .HIGH_WINS (HIGH_WINS)
   ) u_pick (
      .vec_i  (pick_src),
      .pick_o (req_pick)
   );

   pba_timeout #(
      .N_MASTERS (N_MASTERS),
      .LIMIT     (TIMEOUT_CYCLES),
      .CNT_W     (CNT_W)
   ) u_timeout (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .req_i      (req_i),
      .grant_i    (grant_o),
      .expire_o   (expire),
      .cnt_flat_o (cnt_flat)
   );

   pba_park #(
      .N_MASTERS      (N_MASTERS),
      .PARK_MODE      (PARK_MODE),
      .DEFAULT_MASTER (DEFAULT_MASTER)
   ) u_park (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (arb_load),
      .load_vec_i (req_pick),
      .park_vec_o (park_vec)
   );

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         busy_q  <= 1'b0;
         grant_o <= '0;
         mask_q  <= '0;
      end else begin
         busy_q <= bus_busy_i;
         if (release_edge) begin
            grant_o <= '0;
         end else if (bus_busy_i) begin
            grant_o <= grant_o;
         end else if (|expire) begin
            grant_o <= '0;
            mask_q  <= expire;
         end else begin
            grant_o <= grant_next;
            mask_q  <= '0;
         end
      end
   end
endmodule

// File: rtl/prio_bus_arbiter_checker.sv
module prio_bus_arbiter_checker
   import pba_pkg::*;
#(
   parameter int         N_MASTERS      = 4,
   parameter int         TIMEOUT_CYCLES = 10,
   parameter park_mode_e PARK_MODE      = PARK_LAST,
   parameter int         DEFAULT_MASTER = 0,
   parameter int         CNT_W          = 4
) (
   input logic                       clk_i,
   input logic                       rst_i,
   input logic [N_MASTERS-1:0]       req_i,
   input logic                       bus_busy_i,
   input logic [N_MASTERS-1:0]       grant_o,
   input logic [N_MASTERS*CNT_W-1:0] cnt_flat
);
   localparam logic [N_MASTERS-1:0] DFLT = N_MASTERS'(1) << DEFAULT_MASTER;

   assert_grant_onehot_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(grant_o));

   assert_busy_freeze_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      bus_busy_i |=> $stable(grant_o));

   assert_release_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(bus_busy_i) |=> (grant_o == '0));

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_cnt_chk
      logic [CNT_W-1:0] cnt_g;
      assign cnt_g = cnt_flat[g*CNT_W +: CNT_W];

      assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
         cnt_g <= CNT_W'(TIMEOUT_CYCLES));

      assert_count_clear_R10: assert property (@(posedge clk_i) disable iff (rst_i)
         !req_i[g] |=> (cnt_g == '0));
   end

   if (PARK_MODE == PARK_LAST) begin : g_last_chk
      assert_park_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
         (!bus_busy_i && !$fell(bus_busy_i) && req_i == '0 && grant_o != '0)
            |=> $stable(grant_o));
   end else begin : g_dflt_chk
      assert_park_default_R13: assert property (@(posedge clk_i) disable iff (rst_i)
         (!bus_busy_i && !$fell(bus_busy_i) && req_i == '0) |=> (grant_o == DFLT));
   end
endmodule

bind prio_bus_arbiter prio_bus_arbiter_checker #(
   .N_MASTERS      (N_MASTERS),
   .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
   .PARK_MODE      (PARK_MODE),
   .DEFAULT_MASTER (DEFAULT_MASTER),
   .CNT_W          (CNT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .req_i      (req_i),
   .bus_busy_i (bus_busy_i),
   .grant_o    (grant_o),
   .cnt_flat   (cnt_flat)
);

// File: tb/prio_bus_arbiter_bench.sv
`timescale 1ns/1ps
module prio_bus_arbiter_bench;
   import pba_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] req_l  = '0;
   logic       busy_l = 1'b0;
   logic [3:0] gnt_l;
   logic [3:0] req_h  = '0;
   logic       busy_h = 1'b0;
   logic [3:0] gnt_h;
   int checks   = 0;
   int failures = 0;

   always #10 clk = ~clk;

   prio_bus_arbiter #(
      .N_MASTERS(4), .HIGH_WINS(1'b0), .TIMEOUT_CYCLES(10),
      .PARK_MODE(PARK_LAST), .DEFAULT_MASTER(0)
   ) u_prio_bus_arbiter (
      .clk_i(clk), .rst_i(rst), .req_i(req_l), .bus_busy_i(busy_l), .grant_o(gnt_l)
   );

   prio_bus_arbiter #(
      .N_MASTERS(4), .HIGH_WINS(1'b1), .TIMEOUT_CYCLES(10),
      .PARK_MODE(PARK_DEFAULT), .DEFAULT_MASTER(2)
   ) u_prio_bus_arbiter_hi (
      .clk_i(clk), .rst_i(rst), .req_i(req_h), .bus_busy_i(busy_h), .grant_o(gnt_h)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_l = '0; busy_l = 1'b0; req_h = '0; busy_h = 1'b0;
      tick();
      check("R2 reset low-prio", gnt_l, 4'b0000);
      check("R2 reset high-prio", gnt_h, 4'b0000);
      rst = 1'b0;
   endtask

   task automatic t_busy_freeze();
      do_reset();
      req_l = 4'b0010; tick();
      check("R5 single request", gnt_l, 4'b0010);
      busy_l = 1'b1; req_l = 4'b0011; tick();
      check("R3 no preempt", gnt_l, 4'b0010);
      tick();
      check("R3 held while busy", gnt_l, 4'b0010);
      busy_l = 1'b0; tick();
      check("R4 release gap", gnt_l, 4'b0000);
      tick();
      check("R5 lowest wins after gap", gnt_l, 4'b0001);
      req_l = 4'b1110; tick();
      check("R5 lowest of 1110", gnt_l, 4'b0010);
   endtask

   task automatic t_park_last();
      do_reset();
      tick();
      check("R12 nothing granted yet", gnt_l, 4'b0000);
      req_l = 4'b0100; tick();
      check("R5 grant master 2", gnt_l, 4'b0100);
      req_l = 4'b0000; tick();
      check("R11 parked on last", gnt_l, 4'b0100);
      busy_l = 1'b1; tick();
      busy_l = 1'b0; tick();
      check("R4 gap while parked", gnt_l, 4'b0000);
      tick();
      check("R11 returns to last", gnt_l, 4'b0100);
   endtask

   task automatic t_high_default();
      do_reset();
      tick();
      check("R13 default master", gnt_h, 4'b0100);
      req_h = 4'b0011; tick();
      check("R6 highest of 0011", gnt_h, 4'b0010);
      req_h = 4'b1001; tick();
      check("R6 highest of 1001", gnt_h, 4'b1000);
      req_h = 4'b0000; tick();
      check("R13 back to default", gnt_h, 4'b0100);
   endtask

   task automatic t_timeout_exact();
      do_reset();
      req_l = 4'b0011; tick();
      check("R7 first grant", gnt_l, 4'b0001);
      ticks(10);
      check("R7 still held at 11th cycle", gnt_l, 4'b0001);
      tick();
      check("R7 revoked at 12th cycle", gnt_l, 4'b0000);
      tick();
      check("R9 revoked master masked", gnt_l, 4'b0010);
      busy_l = 1'b1; tick();
      check("R3 new owner kept while busy", gnt_l, 4'b0010);
      busy_l = 1'b0; req_l = 4'b0000; tick();
   endtask

   task automatic t_alone();
      do_reset();
      req_l = 4'b0001; ticks(15);
      check("R8 alone never revoked", gnt_l, 4'b0001);
      req_l = 4'b0011; tick();
      check("R7 revoke once other waits", gnt_l, 4'b0000);
      tick();
      check("R9 waiting master served", gnt_l, 4'b0010);
   endtask

   task automatic t_count_clear();
      do_reset();
      req_l = 4'b0011; ticks(8);
      check("R10 held before drop", gnt_l, 4'b0001);
      req_l = 4'b0010; tick();
      check("R10 drop moves grant", gnt_l, 4'b0010);
      req_l = 4'b0011; tick();
      check("R10 regained", gnt_l, 4'b0001);
      ticks(10);
      check("R10 count restarted", gnt_l, 4'b0001);
      tick();
      check("R7 revoke after restart", gnt_l, 4'b0000);
   endtask

   initial begin
      #4_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_busy_freeze();
      t_park_last();
      t_high_default();
      t_timeout_exact();
      t_alone();
      t_count_clear();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule